// File: doc/BRIEF.md
# Quadrant-Folding Sine DAC Switch Decoder

This block is the digital front end of a synthesizer that has no sine lookup table. The phase-to-amplitude mapping happens in an array of current cells. Each cell carries a fixed sine-weighted current. The block receives the truncated phase word once per clock and turns it into switch commands for every cell in the array.

The two top phase bits set the quadrant. The top bit chooses the half period. It does this by steering the active cells to the positive rail or to the negative rail, and it never changes which cells are on. The next bit marks the second and fourth quadrants. When it is set, the six remaining bits are complemented, so the magnitude retraces the quarter wave in reverse. The folded magnitude is split into a row field and a column field. Each field goes through a linear one-hot decoder. The row and column lines are then combined at each cell into a thermometer code.

The cell commands and the polarity choice are captured in one register stage. Every switch therefore moves on the same clock edge. Summing the enabled cell weights with the chosen polarity gives the signed output amplitude. In this project that summing is modelled behaviourally in the bench.

Top module: `sine_dac_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `steer_pos` and `steer_neg` become all zeros at that edge.
- R2: The outputs present after a rising edge depend only on the `phase_in` sampled at that edge. The latency is exactly one clock, and the polarity and cell commands share that latency.
- R3: When `phase_in[6]` is 1, the folded magnitude is the bitwise complement of `phase_in[5:0]`. Phases `{s,1,x}` and `{s,0,~x}` therefore enable the same cells.
- R4: When `phase_in[6]` is 0, the folded magnitude f equals `phase_in[5:0]`. Exactly f+1 cells are enabled, and they are cells 0 through f.
- R5: Cell index i = 8·row + column, with row = f[5:3] and column = f[2:0]. A cell is enabled when its row is below the decoded row, or when its row equals the decoded row and its column is at or below the decoded column.
- R6: With `phase_in[7]` = 0, the enabled cells appear on `steer_pos` and `steer_neg` is all zeros. With `phase_in[7]` = 1, the same cells appear on `steer_neg` and `steer_pos` is all zeros.
- R7: No cell is ever driven on both outputs in the same cycle.
- R8: Take cell weights w_i = round(A·sin(π(i+1)/128)) − round(A·sin(πi/128)) with A = 255, so that each weight is at most 7 units. The signed weighted sum of the enabled cells is then within one unit of ±round(A·sin(π(f+1)/128)), with the sign taken from `phase_in[7]`.
- R9: When the phase advances by one step within a half period, at most one cell changes state.
- R10: The amplitude at phase n equals the amplitude at phase 127−n, and it equals the negated amplitude at phase n+128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_in | input | 8 | Truncated phase word: bit 7 selects the half period, bit 6 the mirrored quadrant, bits 5:0 the magnitude |
| steer_pos | output | 64 | Registered per-cell command to the positive output rail |
| steer_neg | output | 64 | Registered per-cell command to the negative output rail |

## Verification
The bench builds the decoder with its default split of three row bits and three column bits. This gives an eight-bit phase word, so every phase value can be swept in a few hundred cycles. The ascending sweep and the descending sweep cover every quadrant crossing and every row boundary, and they record the amplitude of all 256 phases for the mirror and sign symmetry checks. A stride-37 walk then reaches jumps that cross several rows and quadrants at once. A reset applied in the middle of the run shows that the register stage clears while the phase input is still active.

// File: rtl/sdac_pkg.sv
// Package: shared constants and types for the sine DAC switch decoder.
// Assumes the phase word is two quadrant bits above a row/column magnitude.
package sdac_pkg;
    localparam int ROW_BITS_DFLT = 3;
    localparam int COL_BITS_DFLT = 3;

    // Output polarity: true phase or 180-degree inverted.
    typedef enum logic {
        POL_TRUE   = 1'b0,
        POL_INVERT = 1'b1
    } polarity_e;
endpackage

// File: rtl/quad_fold.sv
// Module: quad_fold
// Splits the phase word into a polarity and a folded quarter-wave magnitude.
// Assumes phase[FOLD_W+1] is the half-period bit and phase[FOLD_W] marks
// the mirrored quadrants. Purely combinational.
module quad_fold
    import sdac_pkg::*;
#(
    parameter int FOLD_W = 6
) (
    input  logic [FOLD_W+1:0] phase,
    output polarity_e         pol,
    output logic [FOLD_W-1:0] mag
);
    logic              mirror;
    logic [FOLD_W-1:0] low_bits;

    // Pick apart the quadrant bits and the magnitude field.
    always_comb begin
        mirror   = phase[FOLD_W];
        low_bits = phase[FOLD_W-1:0];
        pol      = phase[FOLD_W+1] ? POL_INVERT : POL_TRUE;
    end

    // Mirror the magnitude in the second and fourth quadrants.
    always_comb begin
        mag = mirror ? ~low_bits : low_bits;
    end
endmodule

// File: rtl/onehot_decoder.sv
// Module: onehot_decoder
// Linear binary to one-hot decoder used for the row and column lines.
// Assumes IN_W is small (the output has 2**IN_W lines).
module onehot_decoder #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] hot
);
    // One comparator per output line.
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign hot[k] = (code == IN_W'(k));
    end
endmodule

// File: rtl/cell_select.sv
// Module: cell_select
// Local decode at each cell: turns one-hot row and column lines into a
// thermometer over cells indexed row*COLS+col. Assumes each line set is
// one-hot. Combinational.
module cell_select #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    localparam int ROWS  = 1 << ROW_BITS,
    localparam int COLS  = 1 << COL_BITS,
    localparam int CELLS = ROWS * COLS
) (
    input  logic [ROWS-1:0]  row_hot,
    input  logic [COLS-1:0]  col_hot,
    output logic [CELLS-1:0] cell_on
);
    logic [ROWS-1:0] row_above;  // decoded row lies strictly above row r
    logic [COLS-1:0] col_ge;     // decoded column lies at or above column c

    // Prefix-OR over the row lines.
    for (genvar r = 0; r < ROWS; r++) begin : g_rowpfx
        if (r == ROWS - 1) begin : g_top
            assign row_above[r] = 1'b0;
        end else begin : g_mid
            assign row_above[r] = |row_hot[ROWS-1:r+1];
        end
    end

    // Prefix-OR over the column lines.
    for (genvar c = 0; c < COLS; c++) begin : g_colpfx
        assign col_ge[c] = |col_hot[COLS-1:c];
    end

    // Per-cell local decoder.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign cell_on[r*COLS+c] = row_above[r] | (row_hot[r] & col_ge[c]);
        end
    end
endmodule

// File: rtl/switch_latch.sv
// Module: switch_latch
// Synchronous switch stage: gates every cell command with the polarity and
// registers both rails on one edge so all switches move together.
// Assumes a synchronous active-low reset that opens every switch.
module switch_latch
    import sdac_pkg::*;
#(
    parameter int CELLS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] cell_on,
    input  polarity_e        pol,
    output logic [CELLS-1:0] drive_pos,
    output logic [CELLS-1:0] drive_neg
);
    logic [CELLS-1:0] nxt_pos;
    logic [CELLS-1:0] nxt_neg;

    // Steer each enabled cell to the rail chosen by the polarity.
    always_comb begin
        nxt_pos = cell_on & {CELLS{pol == POL_TRUE}};
        nxt_neg = cell_on & {CELLS{pol == POL_INVERT}};
    end

    // Register both rails on a common edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_pos <= '0;
            drive_neg <= '0;
        end else begin
            drive_pos <= nxt_pos;
            drive_neg <= nxt_neg;
        end
    end

    // R1: after a reset edge every switch is open.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (drive_pos == '0 && drive_neg == '0));

    // R7: a cell never drives both rails.
    a_r7_rail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_pos & drive_neg) == '0);
endmodule

// File: rtl/sine_dac_decoder.sv
// Module: sine_dac_decoder (top)
// Folds the phase by quadrant, decodes the magnitude into row and column
// lines, forms a per-cell thermometer and registers it with the polarity.
// Assumes the phase word is ROW_BITS+COL_BITS+2 bits wide; latency is one clock.
module sine_dac_decoder
    import sdac_pkg::*;
#(
    parameter int ROW_BITS = ROW_BITS_DFLT,
    parameter int COL_BITS = COL_BITS_DFLT,
    localparam int FOLD_W  = ROW_BITS + COL_BITS,
    localparam int PHASE_W = FOLD_W + 2,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = 1 << COL_BITS,
    localparam int CELLS   = ROWS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_in,
    output logic [CELLS-1:0]   steer_pos,
    output logic [CELLS-1:0]   steer_neg
);
    polarity_e         pol;
    logic [FOLD_W-1:0] fold_mag;
    logic [ROWS-1:0]   row_hot;
    logic [COLS-1:0]   col_hot;
    logic [CELLS-1:0]  cell_on;
    logic [CELLS-1:0]  cells_q;

    // Quadrant folding.
    quad_fold #(.FOLD_W(FOLD_W)) u_fold (
        .phase (phase_in),
        .pol   (pol),
        .mag   (fold_mag)
    );

    // Row decoder on the upper magnitude field.
    onehot_decoder #(.IN_W(ROW_BITS)) u_row_dec (
        .code (fold_mag[FOLD_W-1:COL_BITS]),
        .hot  (row_hot)
    );

    // Column decoder on the lower magnitude field.
    onehot_decoder #(.IN_W(COL_BITS)) u_col_dec (
        .code (fold_mag[COL_BITS-1:0]),
        .hot  (col_hot)
    );

    // Cell-level thermometer decode.
    cell_select #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_cells (
        .row_hot (row_hot),
        .col_hot (col_hot),
        .cell_on (cell_on)
    );

    // Synchronous polarity-gated switch register.
    switch_latch #(.CELLS(CELLS)) u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_on   (cell_on),
        .pol       (pol),
        .drive_pos (steer_pos),
        .drive_neg (steer_neg)
    );

    // Union of the rails, for the checks below.
    always_comb cells_q = steer_pos | steer_neg;

    // R2 R4: one clock later, exactly folded-magnitude-plus-one cells are on.
    a_r2_count_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(cells_q) == int'($past(fold_mag)) + 1));

    // R5: the enabled set is a contiguous run starting at cell 0.
    a_r5_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cells_q[0] && (((cells_q + 1'b1) & cells_q) == '0)));

    // R6: the rail in use follows the polarity seen one clock earlier.
    a_r6_polarity_rail: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pol) == POL_TRUE) ? (steer_neg == '0) : (steer_pos == '0)));
endmodule

// File: tb/sim_sine_dac_decoder.sv
// Bench: behavioural phase-to-cell reference and weighted-sum amplitude model,
// compared every clock at the falling edge.
module sim_sine_dac_decoder;
    localparam int AMP = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  phase = 8'd0;
    logic [63:0] sp;
    logic [63:0] sn;

    int n_cmp = 0;
    int n_bad = 0;
    int wt[64];
    int amp_of[256];
    int pend[$];
    logic [63:0] prev_set = '0;
    logic        prev_sign = 1'b0;
    bit          have_prev = 1'b0;
    bit          walk_on = 1'b0;

    always #10 clk = ~clk;

    sine_dac_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phase),
        .steer_pos (sp),
        .steer_neg (sn)
    );

    function automatic int sine_units(int k);
        return int'($floor(AMP * $sin(3.14159265358979 * k / 128.0) + 0.5));
    endfunction

    function automatic int fold_of(int p);
        return ((p >> 6) & 1) ? 63 - (p & 63) : (p & 63);
    endfunction

    function automatic logic [63:0] cells_for(int f);
        logic [64:0] t;
        t = (65'd1 << (f + 1)) - 65'd1;
        return t[63:0];
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the outputs against the phase captured at the last rising edge.
    task automatic compare_out();
        int p, f, amp, ea, diff;
        logic [63:0] cur, ecells;
        bit neg;
        if (pend.size() == 0) return;
        p = pend.pop_front();
        f = fold_of(p);
        neg = p[7];
        ecells = cells_for(f);
        cur = sp | sn;
        chk(cur == ecells, "R2", "cell set", cur, ecells);
        if (p[6]) chk($countones(cur) == f + 1, "R3", "mirrored count", $countones(cur), f + 1);
        else chk($countones(cur) == f + 1, "R4", "count", $countones(cur), f + 1);
        chk(cur[f] && (f == 63 || !cur[f+1]), "R5", "thermometer edge", cur, ecells);
        chk(neg ? (sp == 0) : (sn == 0), "R6", "idle rail", neg ? sp : sn, 0);
        chk((sp & sn) == 0, "R7", "both rails", sp & sn, 0);
        amp = 0;
        for (int i = 0; i < 64; i++) begin
            if (sp[i]) amp += wt[i];
            if (sn[i]) amp -= wt[i];
        end
        ea = neg ? -sine_units(f + 1) : sine_units(f + 1);
        diff = amp - ea;
        chk(diff <= 1 && diff >= -1, "R8", "amplitude", amp, ea);
        amp_of[p] = amp;
        if (walk_on && have_prev && prev_sign == neg)
            chk($countones(cur ^ prev_set) <= 1, "R9", "cells moved", $countones(cur ^ prev_set), 1);
        prev_set = cur;
        prev_sign = neg;
        have_prev = 1'b1;
    endtask

    task automatic step(int p);
        @(negedge clk);
        compare_out();
        phase = p[7:0];
        pend.push_back(p & 255);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            wt[i] = sine_units(i + 1) - sine_units(i);
            chk(wt[i] >= 0 && wt[i] <= 7, "R8", "weight range", wt[i], 7);
        end
        phase = 8'hA5;
        repeat (3) @(negedge clk);
        chk(sp == 0 && sn == 0, "R1", "reset outputs", sp | sn, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Full ascending sweep, unit steps.
        walk_on = 1'b1;
        for (int p = 0; p < 256; p++) step(p);
        step(255);
        // Descending sweep.
        for (int p = 255; p >= 0; p--) step(p);
        walk_on = 1'b0;

        // Symmetry about quadrant points (R10).
        for (int n = 0; n < 64; n++) begin
            chk(amp_of[n] == amp_of[127 - n], "R10", "mirror", amp_of[n], amp_of[127 - n]);
            chk(amp_of[n] == -amp_of[n + 128], "R10", "half-period sign", amp_of[n + 128], -amp_of[n]);
        end

        // Large strides crossing rows and quadrants.
        for (int k = 0; k < 300; k++) step((k * 37 + 11) & 255);

        // Boundary phases.
        step(0); step(63); step(64); step(127); step(128); step(191); step(192); step(255);
        step(8); step(7); step(56); step(71);

        // Reset in mid-run with phase still active.
        @(negedge clk);
        compare_out();
        rst_n = 1'b0;
        phase = 8'd200;
        have_prev = 1'b0;
        @(negedge clk);
        chk(sp == 0 && sn == 0, "R1", "mid-run reset", sp | sn, 0);
        rst_n = 1'b1;
        pend.push_back(200);
        step(40);
        step(40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule